// File: doc/BRIEF.md
# Streaming Three-Stage Interference Cancelling Detector

This block makes hard bit decisions for K users who share a channel. Each accepted input is one bit period. It carries one matched-filter sample per user, and the bench holds the past-bit coupling matrix and the current-bit coupling matrix steady. The block first decides every bit from the sign of its sample. Three cancellation stages then refine those decisions in turn. For each user, a stage removes the interference estimated from the earlier stage's decisions on the previous bit, the same bit and the next bit. The stage then takes the sign again.

The stages run at staggered bit indices, two bit periods apart. While the first cancellation stage handles bit n-2, the second handles bit n-4 and the third handles bit n-6. A six-deep delay line keeps the matched-filter samples aligned with each stage. A result leaves the block for every bit period, so no window of bits is buffered. The coupling applied to the next bit's decisions is the transpose of the past-bit matrix, so only two matrices enter the block. Decisions of ±1 are applied by conditional add or subtract, so the block has no multiplier.

A stream is flushed by supplying six further bit periods after its last real bit.

Top module: `pic_detector`

## Requirements
- R1: With both matrices zero, the decision for user j is the sign of that user's sample: +1 when the sample is zero or positive. Output bit j is 1 for +1 and 0 for -1.
- R2: Each cancellation stage forms, for user j at bit n, the value `y[n][j] - sum_k L[j][k]*d[n-1][k] - sum_k C[j][k]*d[n][k] - sum_k L[k][j]*d[n+1][k]`. Here d holds the previous stage's ±1 decisions. The new decision is +1 when this value is zero or positive and -1 otherwise.
- R3: The diagonal entries C[j][j] have no effect on any decision.
- R4: After reset, dec_valid and dec_out are 0. The third-stage decision for bit n is presented in the cycle after the edge that accepts bit n+6. dec_valid is high for exactly that one cycle, so a stream of N bits yields N-6 results in order.
- R5: Bits before the first input after reset count as decision 0, so they contribute no interference.
- R6: The accumulation does not overflow: full-scale 16-bit samples and matrix entries of either sign give the exact sign.
- R7: While in_valid is low, the pipeline does not advance, dec_valid is 0 and dec_out keeps its value.
- R8: User j's sample is in y_in[j*W +: W]. Entry (r,c) of a matrix is in bits [(r*K+c)*W +: W], where r is the user being detected. All values are two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One bit period's samples are present |
| y_in | input | K*W | Matched-filter samples, one per user |
| l_mat | input | K*K*W | Past-bit coupling matrix; its transpose is used for the next bit |
| c_mat | input | K*K*W | Current-bit coupling matrix; diagonal unused |
| dec_out | output | K | Hard decisions, 1 means +1 |
| dec_valid | output | 1 | dec_out holds a new decision vector |

## Verification
Zero matrices with samples that include zero isolate the sign rule and the zero-as-plus-one choice. A single off-diagonal past-bit entry separates L from its transpose and shows a wrong stage alignment. A heavy C diagonal shows whether self-cancellation leaks in. Full-scale values of mixed sign show accumulator overflow, and dense matrices fed with gaps in in_valid check the staggering, the delay-line alignment, the empty history at the start and the holding of the output during gaps. A reference computed over the whole stream, one stage at a time, gives the expected value of every output.

// File: rtl/pic_detector.sv
module pic_detector #(
  parameter int K = 4,
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [K*W-1:0]   y_in,
  input  logic [K*K*W-1:0] l_mat,
  input  logic [K*K*W-1:0] c_mat,
  output logic [K-1:0]     dec_out,
  output logic             dec_valid
);
  localparam int AW = W + $clog2(3*K+1) + 1;
  localparam int YD = 6;

  function automatic logic signed [AW-1:0] ent(input logic [K*K*W-1:0] m, input int r, input int c);
    logic [W-1:0] v;
    v = m[(r*K+c)*W +: W];
    return {{(AW-W){v[W-1]}}, v};
  endfunction

  logic [K*W-1:0] ybuf [0:YD-1];
  logic [K-1:0]   wnz  [0:2][0:2];
  logic [K-1:0]   wng  [0:2][0:2];
  logic [2:0]     cnt;
  logic [3*K-1:0] ng_all;
  logic [2:0]     ok_all;
  logic [K-1:0]   y_neg;

  for (genvar j = 0; j < K; j++) begin : g_sgn
    assign y_neg[j] = y_in[j*W+W-1];
  end

  for (genvar s = 1; s <= 3; s++) begin : g_st
    logic [K-1:0] ng_s;
    assign ok_all[s-1] = (cnt >= 3'(2*s));
    assign ng_all[(s-1)*K +: K] = ng_s;
    always_comb begin : calc
      logic signed [AW-1:0] acc;
      ng_s = '0;
      for (int j = 0; j < K; j++) begin
        acc = {{(AW-W){ybuf[2*s-1][j*W+W-1]}}, ybuf[2*s-1][j*W +: W]};
        for (int k = 0; k < K; k++) begin
          if (wnz[s-1][2][k])
            acc = wng[s-1][2][k] ? acc + ent(l_mat, j, k) : acc - ent(l_mat, j, k);
          if (k != j && wnz[s-1][1][k])
            acc = wng[s-1][1][k] ? acc + ent(c_mat, j, k) : acc - ent(c_mat, j, k);
          if (wnz[s-1][0][k])
            acc = wng[s-1][0][k] ? acc + ent(l_mat, k, j) : acc - ent(l_mat, k, j);
        end
        ng_s[j] = acc[AW-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < YD; i++) ybuf[i] <= '0;
      for (int a = 0; a < 3; a++)
        for (int t = 0; t < 3; t++) begin
          wnz[a][t] <= '0;
          wng[a][t] <= '0;
        end
      cnt       <= '0;
      dec_out   <= '0;
      dec_valid <= 1'b0;
    end else begin
      dec_valid <= 1'b0;
      if (in_valid) begin
        ybuf[0] <= y_in;
        for (int i = 1; i < YD; i++) ybuf[i] <= ybuf[i-1];
        for (int a = 0; a < 3; a++) begin
          wnz[a][2] <= wnz[a][1];
          wnz[a][1] <= wnz[a][0];
          wng[a][2] <= wng[a][1];
          wng[a][1] <= wng[a][0];
        end
        wnz[0][0] <= '1;
        wng[0][0] <= y_neg;
        for (int a = 1; a < 3; a++) begin
          wnz[a][0] <= {K{ok_all[a-1]}};
          wng[a][0] <= ok_all[a-1] ? ng_all[(a-1)*K +: K] : '0;
        end
        if (ok_all[2]) begin
          dec_out   <= ~ng_all[2*K +: K];
          dec_valid <= 1'b1;
        end
        if (cnt < 3'd6) cnt <= cnt + 3'd1;
      end
    end
  end

  // R4
  valid_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(in_valid));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!dec_valid && $stable(dec_out)));

  // R5
  fill_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wnz[2][0] != '0) |-> (wnz[1][0] == '1));

  // R4
  window_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> ($past(wnz[2][1]) == '1));
endmodule

// File: tb/pic_detector_bench.sv
module pic_detector_bench;
  localparam int K = 4, W = 16, MAXN = 48;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [K*W-1:0] y_in = '0;
  logic [K*K*W-1:0] l_mat = '0, c_mat = '0;
  logic [K-1:0] dec_out;
  logic dec_valid;

  pic_detector #(.K(K), .W(W)) u_pic_detector (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .y_in(y_in),
    .l_mat(l_mat), .c_mat(c_mat), .dec_out(dec_out), .dec_valid(dec_valid));

  always #2ns clk = ~clk;

  int n_chk = 0, n_bad = 0, got = 0;
  int ys [0:MAXN-1][0:K-1];
  int lm [0:K-1][0:K-1];
  int cm [0:K-1][0:K-1];
  int dd [0:3][0:MAXN-1][0:K-1];
  int nlen;
  logic [K-1:0] exp_q [$];
  logic [K-1:0] last_out;
  bit seen = 0;
  string tag;

  task automatic chk(input bit ok, input string req, input logic [K-1:0] act, input logic [K-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  function automatic int dv(input int s, input int n, input int k);
    if (n < 0 || n >= nlen) return 0;
    return dd[s][n][k];
  endfunction

  task automatic build_ref();
    for (int n = 0; n < nlen; n++)
      for (int j = 0; j < K; j++) dd[0][n][j] = (ys[n][j] >= 0) ? 1 : -1;
    for (int s = 1; s <= 3; s++)
      for (int n = 0; n < nlen; n++)
        for (int j = 0; j < K; j++) begin
          int acc;
          acc = ys[n][j];
          for (int k = 0; k < K; k++) begin
            acc -= lm[j][k] * dv(s-1, n-1, k);
            if (k != j) acc -= cm[j][k] * dv(s-1, n, k);
            acc -= lm[k][j] * dv(s-1, n+1, k);
          end
          dd[s][n][j] = (acc >= 0) ? 1 : -1;
        end
    for (int n = 0; n + 6 < nlen; n++) begin
      logic [K-1:0] e;
      for (int j = 0; j < K; j++) e[j] = (dd[3][n][j] == 1);
      exp_q.push_back(e);
    end
  endtask

  task automatic run(input int n_in, input bit gaps, input string t);
    tag = t;
    nlen = n_in;
    for (int r = 0; r < K; r++)
      for (int c = 0; c < K; c++) begin
        l_mat[(r*K+c)*W +: W] = 16'(lm[r][c]);
        c_mat[(r*K+c)*W +: W] = 16'(cm[r][c]);
      end
    @(negedge clk); rst_n = 0; in_valid = 0;
    repeat (3) @(negedge clk);
    chk(dec_valid == 1'b0 && dec_out == '0, "R4 reset state", dec_out, '0);
    seen = 0; got = 0;
    exp_q.delete();
    build_ref();
    rst_n = 1;
    for (int n = 0; n < n_in; n++) begin
      @(negedge clk);
      in_valid = 1;
      for (int j = 0; j < K; j++) y_in[j*W +: W] = 16'(ys[n][j]);
      if (gaps && (n % 3 == 2)) begin
        @(negedge clk); in_valid = 0;
        @(negedge clk);
      end
    end
    @(negedge clk); in_valid = 0;
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0 && got == n_in - 6, "R4 result count", K'(got), K'(n_in - 6));
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (dec_valid) begin
        got++;
        if (exp_q.size() == 0) chk(1'b0, "R4 extra output", dec_out, 'x);
        else begin
          logic [K-1:0] e;
          e = exp_q.pop_front();
          chk(dec_out === e, tag, dec_out, e);
        end
        last_out = dec_out;
        seen = 1;
      end else if (seen) begin
        chk(dec_out === last_out, "R7 hold while idle", dec_out, last_out);
      end
    end
  end

  initial begin
    #400us;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: no interference, signs including zero samples
    for (int r = 0; r < K; r++) for (int c = 0; c < K; c++) begin lm[r][c] = 0; cm[r][c] = 0; end
    for (int n = 0; n < 16; n++) for (int j = 0; j < K; j++)
      ys[n][j] = ((n + j) % 4 == 0) ? 0 : (((n * 5 + j * 3) % 7) - 3) * 1000;
    run(16, 0, "R1 sign only");

    // R2 R8: a single past-bit coupling entry, separates L from its transpose
    lm[0][1] = 20000;
    for (int n = 0; n < 20; n++) for (int j = 0; j < K; j++)
      ys[n][j] = (((n * 7 + j * 11) % 9) - 4) * 3000;
    run(20, 0, "R2 R8 transpose use");

    // R3: a heavy C diagonal must be ignored
    for (int r = 0; r < K; r++) for (int c = 0; c < K; c++) begin
      lm[r][c] = ((r + 2 * c) % 3 - 1) * 700;
      cm[r][c] = (r == c) ? 30000 : ((r * 3 + c) % 5 - 2) * 900;
    end
    for (int n = 0; n < 20; n++) for (int j = 0; j < K; j++)
      ys[n][j] = (((n * 13 + j * 5) % 11) - 5) * 1500;
    run(20, 0, "R3 diagonal ignored");

    // R2 R5 R7: dense matrices, empty history at start, gaps in input
    for (int r = 0; r < K; r++) for (int c = 0; c < K; c++) begin
      lm[r][c] = (((r * 7 + c * 13) % 9) - 4) * 1500;
      cm[r][c] = (((r * 5 + c * 3) % 7) - 3) * 1800;
    end
    for (int n = 0; n < 30; n++) for (int j = 0; j < K; j++)
      ys[n][j] = (((n * 31 + j * 17) % 41) - 20) * 800;
    run(30, 1, "R2 R5 R7 dense with gaps");

    // R6: full-scale values of mixed sign
    for (int r = 0; r < K; r++) for (int c = 0; c < K; c++) begin
      lm[r][c] = ((r + c) % 2 == 0) ? -32768 : 32767;
      cm[r][c] = ((r * c) % 2 == 0) ? 32767 : -32768;
    end
    for (int n = 0; n < 20; n++) for (int j = 0; j < K; j++)
      ys[n][j] = ((n + j) % 3 == 0) ? -32768 : (((n * 3 + j) % 2) ? 32767 : -32767);
    run(20, 1, "R6 full scale");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule